// File: doc/BRIEF.md
# FSK Tag Waveform Synthesizer

This block plays the part of a low-frequency tag that answers with frequency-shift keying. Each carrier clock enable produces one coil-modulation sample. Each sample comes from a sub-carrier cycle of one of two lengths. A short cycle spans 8 carrier periods and a long cycle spans 10. Fixed runs of these cycles form half-cells. From those half-cells the block builds a frame from a 44-bit identifier.

A frame starts with a marker made of deliberately invalid cell patterns. The identifier bits follow as Manchester-style cells, most significant bit first. A single extra short cycle is slipped in ahead of every group of four bits. Frames repeat back to back for as long as the block stays enabled.

The surrounding logic supplies a carrier-rate enable, a run enable and the identifier. It drives the coil switch from the modulation output and may use the frame-start pulse for alignment.

Top module: `fsk_tag_synth`

## Requirements
- R1: While reset is asserted, and on every clock after an edge that saw `enable_i` low, `mod_o` and `frame_start_o` are 0.
- R2: A short sub-carrier cycle is 8 samples, 2 high then 6 low. A short half-cell is 6 such cycles, 48 samples in total.
- R3: A long sub-carrier cycle is 10 samples, 3 high then 7 low. A long half-cell is 5 such cycles, 50 samples in total.
- R4: Each frame opens with eight half-cells in the order short, short, short, long, long, long, short, long (392 samples).
- R5: An identifier bit of 1 is a long half-cell followed by a short one. A bit of 0 is a short half-cell followed by a long one.
- R6: Identifier bits are sent from bit 43 down to bit 0.
- R7: One short cycle (8 samples, 2 high then 6 low) is inserted directly before each bit whose index modulo 4 equals 3 (bits 43, 39, …, 3).
- R8: A frame is 4792 samples long and the next frame follows with no gap. `frame_start_o` is high for exactly the sample that opens each frame.
- R9: A sample is produced only on a clock edge that sees `carrier_en_i` and `enable_i` both high. It appears on `mod_o` after that edge. On edges without `carrier_en_i`, `mod_o` holds and `frame_start_o` is 0.
- R10: `id_i` is captured only on the edge that produces a frame's first sample. A change of `id_i` during a frame does not alter that frame.
- R11: Deasserting `enable_i` abandons the current frame. The first sample produced after re-enabling opens a fresh frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| carrier_en_i | input | 1 | One pulse per carrier period; advances one sample |
| enable_i | input | 1 | Run enable; low restarts the frame |
| id_i | input | ID_W (44) | Identifier to transmit |
| mod_o | output | 1 | Coil-modulation sample |
| frame_start_o | output | 1 | High with the first sample of each frame |

## Verification
Each sample is due on `mod_o` one clock after the edge that sees `carrier_en_i` high, so the bench raises the enable just after a falling edge and reads the result at the following falling edge. The frame-start pulse comes out in that same cycle as the sample it marks. Edges without a carrier enable are read one falling edge later and must show the held value. A disable takes effect on the next edge, and the bench checks the outputs at the falling edge right after it. The identifier is captured on the first sample's edge, so mid-frame changes are applied a half cycle before a chosen tick. The frame that is running must still match the old identifier.

// File: rtl/fsk_tag_pkg.sv
package fsk_tag_pkg;

  typedef enum logic [1:0] {
    PH_MARK = 2'd0,
    PH_GAP  = 2'd1,
    PH_DATA = 2'd2
  } phase_e;

endpackage

// File: rtl/fsk_cycle_shaper.sv
module fsk_cycle_shaper #(
  parameter int SHORT_DIV = 8,
  parameter int LONG_DIV  = 10,
  parameter int SHORT_HI  = 2,
  parameter int LONG_HI   = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic clr_i,
  input  logic long_i,
  output logic level_o,
  output logic first_o,
  output logic last_o
);

  localparam int MAX_DIV = (LONG_DIV > SHORT_DIV) ? LONG_DIV : SHORT_DIV;
  localparam int CW      = $clog2(MAX_DIV);

  logic [CW-1:0] smp_q;
  logic [CW-1:0] div_m1;
  logic [CW-1:0] hi_cnt;

  assign div_m1  = long_i ? CW'(LONG_DIV - 1) : CW'(SHORT_DIV - 1);
  assign hi_cnt  = long_i ? CW'(LONG_HI) : CW'(SHORT_HI);
  assign last_o  = (smp_q == div_m1);
  assign first_o = (smp_q == '0);
  assign level_o = (smp_q < hi_cnt);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      smp_q <= '0;
    else if (clr_i)   smp_q <= '0;
    else if (tick_i)  smp_q <= last_o ? '0 : smp_q + CW'(1);
  end

  // R2 R3
  cycle_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_q <= div_m1);

  // R2 R3
  cycle_opens_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && last_o && !clr_i) |=> level_o);

endmodule

// File: rtl/fsk_frame_seq.sv
module fsk_frame_seq
  import fsk_tag_pkg::*;
#(
  parameter int              ID_W       = 44,
  parameter int              GROUP_BITS = 4,
  parameter int              MARK_N     = 8,
  parameter logic [MARK_N-1:0] MARK_PAT = 8'b1011_1000,
  parameter int              SHORT_REP  = 6,
  parameter int              LONG_REP   = 5
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tick_i,
  input  logic            clr_i,
  input  logic            cyc_first_i,
  input  logic            cyc_last_i,
  input  logic [ID_W-1:0] id_i,
  output logic            long_o,
  output logic            frame_first_o
);

  localparam int BW      = $clog2(ID_W);
  localparam int GW      = $clog2(MARK_N);
  localparam int MAX_REP = (LONG_REP > SHORT_REP) ? LONG_REP : SHORT_REP;
  localparam int RW      = $clog2(MAX_REP);

  phase_e        phase_q, phase_d;
  logic [GW-1:0] grp_q, grp_d;
  logic [BW-1:0] bit_q, bit_d;
  logic          half_q, half_d;
  logic [RW-1:0] rep_q, rep_d;
  logic          rep_last;
  logic          grp_end;

  function automatic logic gap_at(int idx);
    return (idx % GROUP_BITS) == (GROUP_BITS - 1);
  endfunction

  always_comb begin
    unique case (phase_q)
      PH_MARK: long_o = MARK_PAT[grp_q];
      PH_GAP:  long_o = 1'b0;
      default: long_o = id_i[bit_q] ^ half_q;
    endcase
  end

  assign rep_last = long_o ? (rep_q == RW'(LONG_REP - 1)) : (rep_q == RW'(SHORT_REP - 1));
  assign grp_end  = (phase_q == PH_GAP) || rep_last;
  assign frame_first_o = (phase_q == PH_MARK) && (grp_q == '0) && (rep_q == '0) && cyc_first_i;

  always_comb begin
    phase_d = phase_q;
    grp_d   = grp_q;
    bit_d   = bit_q;
    half_d  = half_q;
    rep_d   = rep_q;
    if (tick_i && cyc_last_i) begin
      if (!grp_end) begin
        rep_d = rep_q + RW'(1);
      end else begin
        rep_d = '0;
        unique case (phase_q)
          PH_MARK: begin
            if (grp_q == GW'(MARK_N - 1)) begin
              grp_d   = '0;
              bit_d   = BW'(ID_W - 1);
              half_d  = 1'b0;
              phase_d = gap_at(ID_W - 1) ? PH_GAP : PH_DATA;
            end else begin
              grp_d = grp_q + GW'(1);
            end
          end
          PH_GAP: begin
            phase_d = PH_DATA;
            half_d  = 1'b0;
          end
          default: begin
            if (!half_q) begin
              half_d = 1'b1;
            end else begin
              half_d = 1'b0;
              if (bit_q == '0) begin
                phase_d = PH_MARK;
              end else begin
                bit_d   = bit_q - BW'(1);
                phase_d = gap_at(int'(bit_q) - 1) ? PH_GAP : PH_DATA;
              end
            end
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_MARK;
      grp_q   <= '0;
      bit_q   <= '0;
      half_q  <= 1'b0;
      rep_q   <= '0;
    end else if (clr_i) begin
      phase_q <= PH_MARK;
      grp_q   <= '0;
      bit_q   <= '0;
      half_q  <= 1'b0;
      rep_q   <= '0;
    end else begin
      phase_q <= phase_d;
      grp_q   <= grp_d;
      bit_q   <= bit_d;
      half_q  <= half_d;
      rep_q   <= rep_d;
    end
  end

  // R7
  gap_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_GAP) |-> ((int'(bit_q) % GROUP_BITS) == (GROUP_BITS - 1)));

  // R6
  bit_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q != PH_MARK) |-> (int'(bit_q) < ID_W));

  // R5
  half_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_GAP) |-> !half_q);

endmodule

// File: rtl/fsk_tag_synth.sv
module fsk_tag_synth #(
  parameter int              ID_W       = 44,
  parameter int              GROUP_BITS = 4,
  parameter int              MARK_N     = 8,
  parameter logic [MARK_N-1:0] MARK_PAT = 8'b1011_1000,
  parameter int              SHORT_DIV  = 8,
  parameter int              LONG_DIV   = 10,
  parameter int              SHORT_HI   = 2,
  parameter int              LONG_HI    = 3,
  parameter int              SHORT_REP  = 6,
  parameter int              LONG_REP   = 5
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            carrier_en_i,
  input  logic            enable_i,
  input  logic [ID_W-1:0] id_i,
  output logic            mod_o,
  output logic            frame_start_o
);

  logic            tick;
  logic            clr;
  logic            long_sel;
  logic            level;
  logic            cyc_first;
  logic            cyc_last;
  logic            frame_first;
  logic [ID_W-1:0] id_q;
  logic            mod_q;
  logic            fs_q;

  assign tick = carrier_en_i & enable_i;
  assign clr  = ~enable_i;

  fsk_cycle_shaper #(
    .SHORT_DIV (SHORT_DIV),
    .LONG_DIV  (LONG_DIV),
    .SHORT_HI  (SHORT_HI),
    .LONG_HI   (LONG_HI)
  ) u_shaper (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick),
    .clr_i   (clr),
    .long_i  (long_sel),
    .level_o (level),
    .first_o (cyc_first),
    .last_o  (cyc_last)
  );

  fsk_frame_seq #(
    .ID_W       (ID_W),
    .GROUP_BITS (GROUP_BITS),
    .MARK_N     (MARK_N),
    .MARK_PAT   (MARK_PAT),
    .SHORT_REP  (SHORT_REP),
    .LONG_REP   (LONG_REP)
  ) u_seq (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .tick_i        (tick),
    .clr_i         (clr),
    .cyc_first_i   (cyc_first),
    .cyc_last_i    (cyc_last),
    .id_i          (id_q),
    .long_o        (long_sel),
    .frame_first_o (frame_first)
  );

  // identifier is taken only with the first sample of a frame
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   id_q <= '0;
    else if (tick && frame_first)  id_q <= id_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mod_q <= 1'b0;
      fs_q  <= 1'b0;
    end else begin
      fs_q <= tick & frame_first;
      if (!enable_i)  mod_q <= 1'b0;
      else if (tick)  mod_q <= level;
    end
  end

  assign mod_o         = mod_q;
  assign frame_start_o = fs_q;

  // R1
  off_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> (!mod_o && !frame_start_o));

  // R9
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && !carrier_en_i) |=> ($stable(mod_o) && !frame_start_o));

  // R10
  id_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(tick && frame_first) |=> $stable(id_q));

  // R8
  fs_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_o |-> mod_o);

endmodule

// File: tb/fsk_tag_synth_tb.sv
module fsk_tag_synth_tb;

  localparam int FRAME_LEN = 4*6*8 + 4*5*10 + 11*8 + 44*(48+50);

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        carrier_en = 1'b0;
  logic        enable = 1'b0;
  logic [43:0] id = '0;
  logic        mod;
  logic        fs;

  bit ref_bits [0:8191];
  bit got      [0:8191];
  int ref_len;
  int total = 0;
  int bad = 0;
  int gsmp = 0;
  int fs_last = -1;
  int fs_prev = -1;

  localparam logic [43:0] ID_A = 44'hA5C_3F09_16E2;
  localparam logic [43:0] ID_B = 44'h7E1_0C3A_5B96;

  always #2.5 clk = ~clk;

  fsk_tag_synth u_dut (
    .clk_i         (clk),
    .rst_ni        (rst_ni),
    .carrier_en_i  (carrier_en),
    .enable_i      (enable),
    .id_i          (id),
    .mod_o         (mod),
    .frame_start_o (fs)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic add_cyc(input bit lg);
    for (int k = 0; k < (lg ? 10 : 8); k++) begin
      ref_bits[ref_len] = (k < (lg ? 3 : 2));
      ref_len++;
    end
  endtask

  task automatic add_grp(input bit lg);
    for (int c = 0; c < (lg ? 5 : 6); c++) add_cyc(lg);
  endtask

  task automatic build(input logic [43:0] v);
    ref_len = 0;
    add_grp(0); add_grp(0); add_grp(0);
    add_grp(1); add_grp(1); add_grp(1);
    add_grp(0); add_grp(1);
    for (int i = 43; i >= 0; i--) begin
      if ((i % 4) == 3) add_cyc(0);
      add_grp(v[i]);
      add_grp(!v[i]);
    end
  endtask

  task automatic play(input int n, input int gap, input int chg_at, input logic [43:0] chg_id,
                      input string req);
    int mism = 0;
    int fserr = 0;
    int hold = 0;
    int first_bad = -1;
    for (int p = 0; p < n; p++) begin
      if (p == chg_at) id = chg_id;
      carrier_en = 1'b1;
      @(negedge clk);
      got[p] = mod;
      if (mod !== ref_bits[p]) begin
        if (first_bad < 0) first_bad = p;
        mism++;
      end
      if (fs !== (p == 0)) fserr++;
      if (fs === 1'b1) begin
        fs_prev = fs_last;
        fs_last = gsmp;
      end
      gsmp++;
      for (int g = 0; g < gap; g++) begin
        carrier_en = 1'b0;
        @(negedge clk);
        if (mod !== got[p] || fs !== 1'b0) hold++;
      end
    end
    chk(mism == 0, req, $sformatf("sample mismatches (first at %0d)", first_bad), mism, 0);
    chk(fserr == 0, "R8", "frame_start misplacements", fserr, 0);
    if (gap > 0) chk(hold == 0, "R9", "hold violations between ticks", hold, 0);
  endtask

  function automatic int high_count(input int a, input int len);
    int s = 0;
    for (int k = 0; k < len; k++) s += got[a+k];
    return s;
  endfunction

  function automatic int pat8(input int a);
    int v = 0;
    for (int k = 0; k < 8; k++) v = (v << 1) | got[a+k];
    return v;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int off;
    int mstart;
    bit mark_long [8];
    mark_long = '{0, 0, 0, 1, 1, 1, 0, 1};
    id = ID_A;
    repeat (3) @(negedge clk);
    chk(mod === 1'b0 && fs === 1'b0, "R1", "outputs during reset", int'(mod), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    for (int k = 0; k < 5; k++) begin
      carrier_en = 1'b1;
      @(negedge clk);
      chk(mod === 1'b0 && fs === 1'b0, "R1", "outputs while disabled", int'(mod), 0);
    end
    carrier_en = 1'b0;
    @(negedge clk);

    // frame 1, identifier A
    build(ID_A);
    chk(ref_len == FRAME_LEN, "R8", "model frame length", ref_len, FRAME_LEN);
    enable = 1'b1;
    play(ref_len, 0, -1, ID_A, "R4/R5/R6");

    chk(pat8(0) == 8'b1100_0000, "R2", "first short cycle", pat8(0), 8'b1100_0000);
    chk(high_count(0, 48) == 12 && got[48] == 1'b1, "R2", "short half-cell highs", high_count(0, 48), 12);
    chk(high_count(144, 50) == 15 && got[146] && !got[147], "R3", "long half-cell highs", high_count(144, 50), 15);
    mstart = 0;
    for (int g = 0; g < 8; g++) begin
      chk(got[mstart+2] == mark_long[g], "R4", $sformatf("marker group %0d kind", g),
          int'(got[mstart+2]), int'(mark_long[g]));
      mstart += mark_long[g] ? 50 : 48;
    end
    chk(pat8(392) == 8'b1100_0000, "R7", "inserted cycle before bit 43", pat8(392), 8'b1100_0000);
    chk(pat8(392 + 8 + 4*98) == 8'b1100_0000, "R7", "inserted cycle before bit 39",
        pat8(392 + 8 + 4*98), 8'b1100_0000);
    chk(got[402] == ID_A[43], "R6", "first data half follows bit 43", int'(got[402]), int'(ID_A[43]));
    off = 400 + (ID_A[43] ? 50 : 48);
    chk(got[off+2] == !ID_A[43], "R5", "second half of bit 43 cell", int'(got[off+2]), int'(!ID_A[43]));
    chk(got[500] == ID_A[42], "R6", "first half of bit 42 cell", int'(got[500]), int'(ID_A[42]));

    // frame 2: identifier changes mid-frame, frame stays A
    play(ref_len, 0, 1000, ID_B, "R10");
    chk(fs_last - fs_prev == FRAME_LEN, "R8", "spacing of frame starts", fs_last - fs_prev, FRAME_LEN);

    // frame 3: identifier B with idle clocks between ticks
    build(ID_B);
    play(ref_len, 2, -1, ID_B, "R9");

    // partial frame, then disable and restart
    play(500, 0, -1, ID_B, "R9");
    enable = 1'b0;
    for (int k = 0; k < 4; k++) begin
      carrier_en = 1'b1;
      @(negedge clk);
      chk(mod === 1'b0 && fs === 1'b0, "R1", "outputs after disable", int'(mod), 0);
    end
    enable = 1'b1;
    play(ref_len, 0, 4000, 44'h0, "R11");

    build(44'h0);
    play(ref_len, 0, 3000, {44{1'b1}}, "R5");
    build({44{1'b1}});
    play(ref_len, 1, -1, {44{1'b1}}, "R5");

    carrier_en = 1'b0;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule